// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block is a master-mode serial output port for a two-channel measurement path. Upstream logic hands it a voltage word and a current word together with a one-cycle strobe. The port then produces its own bit clock, a one-period frame marker and a data line, and sends one frame per sample. The bit clock only toggles during the data burst. Between bursts, and while the frame marker is high, it rests low.

A frame carries six 16-bit slots sent most significant bit first. The voltage word is sent first and the current word second. The last four slots are always zero. The bit clock is the master clock divided by 8 or by 4, chosen by a rate input. The words and the rate are captured when a frame begins, so a new sample or a rate change during a frame does not disturb that frame. Samples that arrive during a frame are held, and only the newest is sent next. Each output has a companion drive-enable that follows an enable pin, so a pad ring can float the lines.

Top module: `ssp_serial_tx`

## Requirements
- R1: While reset is low at a clock edge, and from then until a new sample is taken, the bit clock, the frame marker and the data line are all low. A strobe seen during reset is dropped.
- R2: When a strobe is registered in idle, the frame marker goes high on the next edge. It stays high for exactly one bit-clock period: 8 master cycles at the slow rate, 4 at the fast rate.
- R3: The bit clock is low while the frame marker is high and while the port is idle. After the marker falls, the bit clock gives exactly 96 periods. Each period starts with its low half. The clock then stays low.
- R4: Burst bit k (k from 0) carries voltage bit 15-k for k below 16, current bit 31-k for k from 16 to 31, and 0 for k from 32 to 95.
- R5: The data line changes only together with a falling bit-clock edge or at the start of the burst. It is stable while the bit clock is high.
- R6: With the rate input at 0, each bit-clock half lasts 4 master cycles; with it at 1, each half lasts 2. The rate value sampled on the edge that starts a frame holds for the whole frame.
- R7: Each of the three drive-enable outputs equals the enable input. The enable has no effect on the frame timing or content.
- R8: Both words are captured on the edge that starts a frame. Strobes during that frame do not change the bits being sent.
- R9: If one or more strobes arrive during a frame, a new frame marker starts on the edge right after the last bit period ends. That frame carries the words of the most recent strobe.
- R10: The data line is low whenever no burst bit is being sent, that is while idle and while the frame marker is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_fast_i | input | 1 | 1 selects divide-by-4 bit clock, 0 divide-by-8 |
| port_en_i | input | 1 | Drive enable for the three serial lines |
| smp_stb_i | input | 1 | One-cycle strobe: new sample on volt_i and curr_i |
| volt_i | input | 16 | Voltage sample word |
| curr_i | input | 16 | Current sample word |
| sclk_o | output | 1 | Bit clock |
| sclk_oe_o | output | 1 | Drive enable for sclk_o |
| frame_o | output | 1 | Frame marker |
| frame_oe_o | output | 1 | Drive enable for frame_o |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |

## Verification
The bench drives single isolated samples at both rates. It uses asymmetric words (0xA5C3 with 0x8001, all ones with all zeros), so a swapped slot, a reversed bit order or a stray bit in the zero slots shows up as a clear mismatch. Strobes placed in the middle of a burst, including two in a row, separate latching at frame start from live pass-through, and show whether the newest sample or an older one is sent back to back. A rate flip during a frame, an enable toggle and a reset in the middle of a frame show that each control acts only where it should.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int WORD_W      = 16;
    localparam int FRAME_SLOTS = 6;
    localparam int LIVE_SLOTS  = 2;
    localparam int SLOW_HALF   = 4;
    localparam int FAST_HALF   = 2;

    localparam int FRAME_BITS = FRAME_SLOTS * WORD_W;
    localparam int LIVE_BITS  = LIVE_SLOTS * WORD_W;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);
    localparam int PH_W       = $clog2(2 * SLOW_HALF);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_MARK  = 2'd1,
        SEQ_BURST = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] volt;
        logic [WORD_W-1:0] curr;
    } sample_pair_t;

    function automatic logic [PH_W-1:0] half_len(input logic fast);
        return fast ? PH_W'(FAST_HALF) : PH_W'(SLOW_HALF);
    endfunction

endpackage

// File: rtl/ssp_rate_timer.sv
module ssp_rate_timer
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic period_end,
    output logic upper_half
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] half_w;

    assign half_w     = half_len(fast);
    assign period_end = (phase_q == ((half_w << 1) - PH_W'(1)));
    assign upper_half = (phase_q >= half_w);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (period_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end
endmodule

// File: rtl/ssp_sample_hold.sv
module ssp_sample_hold
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [WORD_W-1:0] volt,
    input  logic [WORD_W-1:0] curr,
    input  logic              take,
    output sample_pair_t      held,
    output logic              pending
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= '0;
            pending <= 1'b0;
        end else if (stb) begin
            held.volt <= volt;
            held.curr <= curr;
            pending   <= 1'b1;
        end else if (take) begin
            pending   <= 1'b0;
        end
    end
endmodule

// File: rtl/ssp_frame_seq.sv
module ssp_frame_seq
    import ssp_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pending,
    input  sample_pair_t held,
    input  logic         rate_fast,
    input  logic         period_end,
    input  logic         upper_half,
    output logic         take,
    output logic         run,
    output logic         rate_q,
    output logic         sclk,
    output logic         mark,
    output logic         sdo
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_BITS - 1);

    seq_state_t             state_q;
    logic [BIT_IDX_W-1:0]   bit_q;
    logic [LIVE_BITS-1:0]   shreg_q;
    logic                   burst_done;

    assign burst_done = (state_q == SEQ_BURST) && period_end && (bit_q == LAST_BIT);
    assign take       = pending && ((state_q == SEQ_IDLE) || burst_done);
    assign run        = (state_q != SEQ_IDLE);
    assign mark       = (state_q == SEQ_MARK);
    assign sclk       = (state_q == SEQ_BURST) && upper_half;
    assign sdo        = (state_q == SEQ_BURST) && shreg_q[LIVE_BITS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            bit_q   <= '0;
            shreg_q <= '0;
            rate_q  <= 1'b0;
        end else begin
            if (take) begin
                state_q <= SEQ_MARK;
                shreg_q <= held;
                rate_q  <= rate_fast;
                bit_q   <= '0;
            end else begin
                unique case (state_q)
                    SEQ_IDLE: ;
                    SEQ_MARK: begin
                        if (period_end) begin
                            state_q <= SEQ_BURST;
                            bit_q   <= '0;
                        end
                    end
                    SEQ_BURST: begin
                        if (period_end) begin
                            if (bit_q == LAST_BIT) begin
                                state_q <= SEQ_IDLE;
                            end else begin
                                bit_q   <= bit_q + BIT_IDX_W'(1);
                                shreg_q <= {shreg_q[LIVE_BITS-2:0], 1'b0};
                            end
                        end
                    end
                    default: state_q <= SEQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ssp_serial_tx.sv
module ssp_serial_tx
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_fast_i,
    input  logic              port_en_i,
    input  logic              smp_stb_i,
    input  logic [WORD_W-1:0] volt_i,
    input  logic [WORD_W-1:0] curr_i,
    output logic              sclk_o,
    output logic              sclk_oe_o,
    output logic              frame_o,
    output logic              frame_oe_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    sample_pair_t held_w;
    logic pending_w, take_w, run_w, rate_q_w, period_end_w, upper_half_w;

    ssp_sample_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (smp_stb_i),
        .volt    (volt_i),
        .curr    (curr_i),
        .take    (take_w),
        .held    (held_w),
        .pending (pending_w)
    );

    ssp_rate_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_w),
        .fast       (rate_q_w),
        .period_end (period_end_w),
        .upper_half (upper_half_w)
    );

    ssp_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending_w),
        .held       (held_w),
        .rate_fast  (rate_fast_i),
        .period_end (period_end_w),
        .upper_half (upper_half_w),
        .take       (take_w),
        .run        (run_w),
        .rate_q     (rate_q_w),
        .sclk       (sclk_o),
        .mark       (frame_o),
        .sdo        (sdo_o)
    );

    assign sclk_oe_o  = port_en_i;
    assign frame_oe_o = port_en_i;
    assign sdo_oe_o   = port_en_i;
endmodule

// File: rtl/ssp_port_checks.sv
module ssp_port_checks
    import ssp_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic frame_o,
    input logic sdo_o
);
    logic [7:0] mark_len_q;
    logic [7:0] rise_cnt_q;
    logic       sclk_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_len_q  <= '0;
            rise_cnt_q  <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_o;
            if (frame_o) begin
                mark_len_q <= mark_len_q + 8'd1;
                rise_cnt_q <= '0;
            end else begin
                mark_len_q <= '0;
                if (sclk_o && !sclk_prev_q) rise_cnt_q <= rise_cnt_q + 8'd1;
            end
        end
    end

    // R3: bit clock rests while the frame marker is up
    a_r3_sclk_quiet_in_mark: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> !sclk_o);

    // R10: data line low during the marker
    a_r10_sdo_low_in_mark: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> !sdo_o);

    // R5: data steady through a high bit-clock phase
    a_r5_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R2: marker lasts one bit-clock period of either rate
    a_r2_mark_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_o) |-> ((mark_len_q == 8'(2 * FAST_HALF)) || (mark_len_q == 8'(2 * SLOW_HALF))));

    // R3: a new marker follows either nothing or a full burst of rising edges
    a_r3_full_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> ((rise_cnt_q == 8'd0) || (rise_cnt_q == 8'(FRAME_BITS))));

    // R1: the edge after reset leaves every line low
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sclk_o && !frame_o && !sdo_o));
endmodule

bind ssp_serial_tx ssp_port_checks u_port_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_o  (sclk_o),
    .frame_o (frame_o),
    .sdo_o   (sdo_o)
);

// File: tb/test_ssp_serial_tx.sv
`timescale 1ns/1ps
module test_ssp_serial_tx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rate_fast_i = 1'b0;
    logic port_en_i = 1'b1;
    logic smp_stb_i = 1'b0;
    logic [15:0] volt_i = '0;
    logic [15:0] curr_i = '0;
    logic sclk_o, sclk_oe_o, frame_o, frame_oe_o, sdo_o, sdo_oe_o;

    always #2 clk = ~clk;

    ssp_serial_tx i_ssp_serial_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_fast_i (rate_fast_i),
        .port_en_i   (port_en_i),
        .smp_stb_i   (smp_stb_i),
        .volt_i      (volt_i),
        .curr_i      (curr_i),
        .sclk_o      (sclk_o),
        .sclk_oe_o   (sclk_oe_o),
        .frame_o     (frame_o),
        .frame_oe_o  (frame_oe_o),
        .sdo_o       (sdo_o),
        .sdo_oe_o    (sdo_oe_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R4";
    bit    done = 1'b0;

    // reference model: queue of expected {sclk, frame, sdo} per master cycle
    logic [2:0]  exp_q[$];
    logic [2:0]  exp_now = 3'b000;
    bit          mdl_pend = 1'b0;
    logic [15:0] mdl_v = '0;
    logic [15:0] mdl_i = '0;

    task automatic launch(input bit fast, input logic [15:0] v, input logic [15:0] c);
        int h;
        logic d;
        h = fast ? 2 : 4;
        for (int k = 0; k < 2 * h; k++) exp_q.push_back(3'b010);
        for (int b = 0; b < 96; b++) begin
            if (b < 16)      d = v[15 - b];
            else if (b < 32) d = c[31 - b];
            else             d = 1'b0;
            for (int k = 0; k < h; k++) exp_q.push_back({1'b0, 1'b0, d});
            for (int k = 0; k < h; k++) exp_q.push_back({1'b1, 1'b0, d});
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            mdl_pend = 1'b0;
            mdl_v = '0;
            mdl_i = '0;
            exp_now = 3'b000;
        end else begin
            bit started;
            started = 1'b0;
            if (exp_q.size() == 0 && mdl_pend) begin
                launch(rate_fast_i, mdl_v, mdl_i);
                started = 1'b1;
            end
            if (smp_stb_i) begin
                mdl_v = volt_i;
                mdl_i = curr_i;
                mdl_pend = 1'b1;
            end else if (started) begin
                mdl_pend = 1'b0;
            end
            exp_now = (exp_q.size() != 0) ? exp_q.pop_front() : 3'b000;
        end
    end

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", t, what, act, exp, $time);
        end
    endtask

    logic sclk_last = 1'b0;
    logic sdo_last  = 1'b0;

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R3", {tag, " sclk"}, 32'(sclk_o), 32'(exp_now[2]));
            chk("R2", {tag, " frame"}, 32'(frame_o), 32'(exp_now[1]));
            chk("R4", {tag, " sdo"}, 32'(sdo_o), 32'(exp_now[0]));
            chk("R7", "drive enables", {29'd0, sclk_oe_o, frame_oe_o, sdo_oe_o}, {29'd0, {3{port_en_i}}});
            if (exp_now[1] || exp_now == 3'b000)
                chk("R10", "sdo idle low", 32'(sdo_o), 32'(exp_now[0]));
            if (sclk_o && sclk_last)
                chk("R5", "sdo steady while sclk high", 32'(sdo_o), 32'(sdo_last));
            sclk_last = sclk_o;
            sdo_last  = sdo_o;
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic strobe(input logic [15:0] v, input logic [15:0] c);
        volt_i = v;
        curr_i = c;
        smp_stb_i = 1'b1;
        tick(1);
        smp_stb_i = 1'b0;
        volt_i = 16'hDEAD;
        curr_i = 16'hBEEF;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        // R1: reset state, strobe during reset dropped
        tag = "R1";
        tick(2);
        strobe(16'h1234, 16'h5678);
        tick(2);
        #1;
        chk("R1", "lines low in reset", {29'd0, sclk_o, frame_o, sdo_o}, 32'd0);
        rst_n = 1'b1;
        tick(20);
        chk("R1", "idle after reset", {29'd0, sclk_o, frame_o, sdo_o}, 32'd0);

        // R4 / R6: slow rate, asymmetric words
        tag = "R6 slow";
        rate_fast_i = 1'b0;
        strobe(16'hA5C3, 16'h8001);
        tick(800);

        // fast rate with extreme words
        tag = "R6 fast";
        rate_fast_i = 1'b1;
        strobe(16'hFFFF, 16'h0000);
        tick(420);

        // R8: strobe mid-burst must not alter the frame in flight
        // R9: two strobes mid-frame, newest sent immediately after
        tag = "R8 R9";
        rate_fast_i = 1'b0;
        strobe(16'h0F0F, 16'hF0F0);
        tick(100);
        strobe(16'h1111, 16'h2222);
        tick(50);
        strobe(16'h8000, 16'h0001);
        tick(1700);

        // R6: rate flip in mid-frame has no effect until the next frame
        tag = "R6 flip";
        rate_fast_i = 1'b1;
        strobe(16'h3C3C, 16'hC3C3);
        tick(30);
        rate_fast_i = 1'b0;
        tick(30);
        rate_fast_i = 1'b1;
        tick(400);

        // R7: enable toggles during a frame, timing unchanged
        tag = "R7";
        strobe(16'h5A5A, 16'h6969);
        tick(40);
        port_en_i = 1'b0;
        tick(5);
        chk("R7", "sclk enable off", 32'(sclk_oe_o), 32'd0);
        tick(100);
        port_en_i = 1'b1;
        tick(300);

        // R1: reset in the middle of a frame returns to idle
        tag = "R1 mid";
        strobe(16'h7777, 16'h9999);
        tick(200);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(50);
        chk("R1", "idle after mid-frame reset", {29'd0, sclk_o, frame_o, sdo_o}, 32'd0);

        finish_run();
    end

endmodule